// File: doc/BRIEF.md
# Subpixel Delta-Sigma Colour LSB Extender

This block widens the effective resolution of a small resistor DAC colour channel. A 6-bit colour component arrives once per pixel, together with a strobe, on a subpixel clock that runs several times faster than the pixel clock. The three most significant input bits drive the three upper DAC bits unchanged. The lowest DAC bit becomes a serial bit stream whose density of ones stands for the remaining three input bits, so the analog filtering after the DAC averages it to a level between two DAC steps.

The stream comes from a first-order delta-sigma accumulator that runs without a break across pixel boundaries. It is never restarted on a new pixel. This keeps the energy left over from one pixel's pattern from biasing the level of the next. A field of all ones gives a constant high, and a field of zero gives a constant low. One instance handles one colour channel, so an RGB output uses three instances side by side.

Top module: `lsb_sigma_extender`

## Requirements
- R1: A synchronous active-high reset drives `dac_out` to 0 at the next subpixel edge. It also clears the held pixel and the accumulator, so the slot sequence starts from an accumulator value of zero.
- R2: `pix_in` is captured only at an edge where `pix_stb` is high. At any other edge a change on `pix_in` has no effect on `dac_out`.
- R3: When a value is captured at edge k, `dac_out[3:1]` equals bits [5:3] of that value from edge k+1 onward, until the next capture.
- R4: Let v be bits [2:0] of the held value. Over any 7 consecutive subpixel slots in which v is constant, `dac_out[0]` is high in exactly v slots.
- R5: With v = 7, `dac_out[0]` is high in every slot. With v = 0, it is low in every slot.
- R6: The accumulator holds a value a in the range 0..6. At each slot s = a + v. The emitted bit is 1 when s >= 7, and the next a is s - 7 in that case, otherwise s.
- R7: A pixel strobe does not reset the accumulator. Its value carries across pixel boundaries, including a re-strobe of the same value.
- R8: While the held value is unchanged, `dac_out[3:1]` stays constant in every slot. Only bit 0 varies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sub | input | 1 | Subpixel clock, a whole multiple of the pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | High for one subpixel cycle per pixel; loads `pix_in` |
| pix_in | input | 6 | Colour component for the next pixel |
| dac_out | output | 4 | Registered drive code for the resistor DAC |

## Verification
A value strobed at edge k is held from edge k and reaches `dac_out` at edge k+1, so both the upper bits and the new bit density are due one edge after the strobe edge. The bench keeps a slot-by-slot reference of the accumulator rule. It advances this reference once per edge, using the inputs present before that edge, and compares `dac_out` a short time after the edge. The density windows for R4 start only at the slot after the strobe edge, so every 7-slot window sees a single constant field. Reset is likewise checked at the first sample after the edge that sampled it high.

// File: rtl/lsbx_pkg.sv
package lsbx_pkg;
  // Width of the low input field that is spread over the DAC's last bit:
  // the bits below the upper DAC bits plus the DAC LSB position itself.
  function automatic int lsb_field_w(input int in_w, input int dac_w);
    return in_w - dac_w + 1;
  endfunction

  // Modulus of the accumulator: an all-ones field means a constant high.
  function automatic int lsb_modulus(input int field_w);
    return (1 << field_w) - 1;
  endfunction
endpackage

// File: rtl/lsbx_capture.sv
module lsbx_capture #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst)       hold <= '0;
    else if (load) hold <= din;
  end
endmodule

// File: rtl/lsbx_dsmod.sv
module lsbx_dsmod #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] lvl,
  output logic          bit_q
);
  import lsbx_pkg::*;
  localparam int          MOD_I = lsb_modulus(FW);
  localparam logic [FW:0] MODV  = (FW+1)'(MOD_I);

  logic [FW-1:0] acc;
  logic [FW:0]   sum;
  logic          hit;
  logic [FW:0]   nxt;

  always_comb begin
    sum = {1'b0, acc} + {1'b0, lvl};
    hit = (sum >= MODV);
    nxt = hit ? (sum - MODV) : sum;
  end

  // Accumulator never restarts on a pixel boundary: only reset clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      bit_q <= 1'b0;
    end else begin
      acc   <= nxt[FW-1:0];
      bit_q <= hit;
    end
  end

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, acc} < MODV); // R6
  AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
    (lvl == FW'(MOD_I)) |=> bit_q); // R5
  AST_FULL_OFF: assert property (@(posedge clk) disable iff (rst)
    (lvl == '0) |=> !bit_q); // R5
endmodule

// File: rtl/lsb_sigma_extender.sv
module lsb_sigma_extender #(
  parameter int IN_W  = 6,
  parameter int DAC_W = 4
) (
  input  logic             clk_sub,
  input  logic             rst,
  input  logic             pix_stb,
  input  logic [IN_W-1:0]  pix_in,
  output logic [DAC_W-1:0] dac_out
);
  import lsbx_pkg::*;
  localparam int FW = lsb_field_w(IN_W, DAC_W);
  localparam int HW = DAC_W - 1;

  logic [IN_W-1:0] held;
  logic [HW-1:0]   hi_q;
  logic            lsb_bit;

  lsbx_capture #(.W(IN_W)) u_cap (
    .clk  (clk_sub),
    .rst  (rst),
    .load (pix_stb),
    .din  (pix_in),
    .hold (held)
  );

  lsbx_dsmod #(.FW(FW)) u_mod (
    .clk   (clk_sub),
    .rst   (rst),
    .lvl   (held[FW-1:0]),
    .bit_q (lsb_bit)
  );

  // Upper bits pass straight through, aligned with the modulator register.
  always_ff @(posedge clk_sub) begin
    if (rst) hi_q <= '0;
    else     hi_q <= held[IN_W-1:FW];
  end

  assign dac_out = {hi_q, lsb_bit};

  AST_RESET_ZERO: assert property (@(posedge clk_sub)
    rst |=> (dac_out == '0)); // R1
  AST_UPPER_PASS: assert property (@(posedge clk_sub) disable iff (rst)
    pix_stb |=> ##1 (dac_out[DAC_W-1:1] == $past(pix_in[IN_W-1:FW], 2))); // R3
  AST_UPPER_STEADY: assert property (@(posedge clk_sub) disable iff (rst)
    (!pix_stb && !$past(pix_stb) && !$past(rst)) |=> $stable(dac_out[DAC_W-1:1])); // R8
endmodule

// File: tb/lsb_sigma_extender_test.sv
module lsb_sigma_extender_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_stb = 1'b0;
  logic [5:0] pix_in = '0;
  logic [3:0] dac_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [5:0] m_hold = '0;
  int         m_acc = 0;
  logic [3:0] m_out = '0;

  // Stimulus and expected results: {value[5:0], ones per 7 slots[2:0], upper[2:0]}
  localparam logic [11:0] VEC [8] = '{
    {6'h00, 3'd0, 3'd0}, {6'h3F, 3'd7, 3'd7}, {6'h2A, 3'd2, 3'd5}, {6'h15, 3'd5, 3'd2},
    {6'h0C, 3'd4, 3'd1}, {6'h3B, 3'd3, 3'd7}, {6'h31, 3'd1, 3'd6}, {6'h1E, 3'd6, 3'd3}
  };

  always #5 clk = ~clk;

  lsb_sigma_extender uut (
    .clk_sub (clk),
    .rst     (rst),
    .pix_stb (pix_stb),
    .pix_in  (pix_in),
    .dac_out (dac_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance the reference by one slot (R6), then let the edge happen.
  task automatic step();
    int s;
    if (rst) begin
      m_hold = '0; m_acc = 0; m_out = '0;
    end else begin
      s = m_acc + int'(m_hold[2:0]);
      m_out = {m_hold[5:3], (s >= 7)};
      m_acc = (s >= 7) ? s - 7 : s;
      if (pix_stb) m_hold = pix_in;
    end
    @(posedge clk);
    #2;
  endtask

  task automatic step_cmp(input string req);
    step();
    chk(dac_out == m_out, req, int'(dac_out), int'(m_out));
  endtask

  task automatic load(input logic [5:0] v);
    pix_in = v; pix_stb = 1'b1;
    step();
    pix_stb = 1'b0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ones;
    #2;
    step(); step();
    chk(dac_out == 4'd0, "R1 reset", int'(dac_out), 0);
    rst = 1'b0;

    // Table walk: R3, R4, R8, plus per-slot R6
    for (int i = 0; i < 8; i++) begin
      load(VEC[i][11:6]);
      ones = 0;
      for (int k = 0; k < 7; k++) begin
        step_cmp("R6 slot");
        ones += int'(dac_out[0]);
        chk(dac_out[3:1] == VEC[i][2:0], "R3 upper", int'(dac_out[3:1]), int'(VEC[i][2:0]));
      end
      chk(ones == int'(VEC[i][5:3]), "R4 density", ones, int'(VEC[i][5:3]));
    end

    // R5: full on and full off over long runs
    load(6'h07);
    for (int k = 0; k < 20; k++) begin
      step();
      chk(dac_out[0] == 1'b1, "R5 full on", int'(dac_out[0]), 1);
    end
    load(6'h38);
    for (int k = 0; k < 20; k++) begin
      step();
      chk(dac_out[0] == 1'b0, "R5 full off", int'(dac_out[0]), 0);
    end

    // R2: changes without strobe are ignored; R8 upper steady
    load(6'h2A);
    ones = 0;
    for (int k = 0; k < 14; k++) begin
      pix_in = 6'(k * 13 + 5);
      step_cmp("R2 ignore");
      ones += int'(dac_out[0]);
      chk(dac_out[3:1] == 3'd5, "R8 steady", int'(dac_out[3:1]), 5);
    end
    chk(ones == 4, "R2 density held", ones, 4);

    // R7: re-strobing the same value continues the accumulator phase
    load(6'h03);
    step_cmp("R7 run"); step_cmp("R7 run");
    for (int k = 0; k < 4; k++) begin
      pix_in = 6'h03; pix_stb = 1'b1;
      step_cmp("R7 restrobe");
      pix_stb = 1'b0;
      step_cmp("R7 continue");
    end

    // R1 mid-run reset then exact sequence for v=4 (R6): 0,1,0,1,0,1,1
    rst = 1'b1;
    step();
    chk(dac_out == 4'd0, "R1 mid reset", int'(dac_out), 0);
    rst = 1'b0;
    load(6'h04);
    for (int k = 0; k < 7; k++) begin
      step();
      chk(dac_out[0] == ((k % 2 == 1) || k == 6), "R6 sequence",
          int'(dac_out[0]), int'((k % 2 == 1) || k == 6));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule